// File: doc/BRIEF.md
# UART Bit-Rate Tick Generator

This block produces the bit-rate enable pulse that a UART transmitter and receiver step on. It holds a 32-bit rate configuration word that carries a 23-bit divisor and two mode flags. It counts either every functional clock cycle through a fixed divide-by-4 prescaler, or the pulses of a crystal reference through a fixed divide-by-3 prescaler. After the prescaler, a (divisor + 1) counter sets the bit period. The crystal reference reaches the block as a clock-enable strobe in the functional clock domain, so the block has no clock-domain crossing.

Software writes the configuration word only when the transmitter is fully idle. A write restarts the prescaler and the divisor counter from zero, so the first tick after a write comes exactly one bit period later. Until software writes a word with the "use programmed divisor" flag set, the block runs at a built-in default rate. That rate is close to 115200 baud with a 125 MHz functional clock. The block reports through `cfg_valid` whether the programmed divisor is in force.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `bit_tick` and `cfg_valid` are low, and ticks follow at the default rate of one every 4 × (DEFAULT_DIV + 1) cycles, where DEFAULT_DIV is 270.
- R2: `cfg_valid` equals bit 23 of the most recent configuration write and changes only on a write.
- R3: With bit 23 set and bit 24 clear, ticks follow every 4 × (D + 1) functional clock cycles, where D is bits [22:0]. `xtal_en` has no effect in this mode.
- R4: With bits 23 and 24 both set, ticks follow every 3 × (D + 1) cycles in which `xtal_en` is high, whatever the spacing of those strobes.
- R5: With bit 23 clear, the block runs at the default rate of R1, and bit 24 and bits [22:0] of the write are ignored.
- R6: A write restarts counting. The cycle after a write carries no tick. The first tick comes exactly one full bit period (R3, R4 or R5) after the write edge.
- R7: Each tick is high for exactly one functional clock cycle.
- R8: A divisor of zero gives the maximum rate: a tick every 4 cycles in functional mode, or every 3 strobes in crystal mode.
- R9: In crystal mode, a tick only appears in the cycle that follows a cycle in which `xtal_en` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word: [22:0] divisor, [23] use programmed divisor, [24] crystal source |
| xtal_en | input | 1 | One-cycle strobe per crystal reference period |
| bit_tick | output | 1 | One-cycle pulse per bit period |
| cfg_valid | output | 1 | High while the programmed divisor is in force |

## Verification
In functional mode the crystal strobe is toggled pseudo-randomly, so that a design which counts the wrong source gives a wrong period. In crystal mode the same irregular strobe is used, and the bench counts the strobes between ticks rather than cycles. This tells true strobe counting apart from a fixed cycle count. A word with the mode bit set but bit 23 clear checks that the default rate wins. A rewrite partway through a period shows whether the counters restart or run on. Divisor zero in both modes checks the shortest period and its one-cycle-wide tick.

// File: rtl/baud_tick_pkg.sv
// Package: shared field positions and types for the bit-rate tick generator.
// Assumes a 32-bit configuration word with the divisor in the low bits.
package baud_tick_pkg;
    localparam int unsigned CFG_W   = 32;
    localparam int unsigned DIV_W   = 23;
    localparam int unsigned USE_BIT = DIV_W;      // programmed divisor in force
    localparam int unsigned SRC_BIT = DIV_W + 1;  // crystal reference selected

    typedef enum logic {
        SRC_FUNC = 1'b0,
        SRC_XTAL = 1'b1
    } baud_src_e;
endpackage

// File: rtl/baud_cfg_reg.sv
// Holds the decoded rate configuration. A write with the use flag clear
// falls back to the default divisor on the functional clock.
// Assumes writes happen only while the transmitter is idle.
module baud_cfg_reg
    import baud_tick_pkg::*;
#(
    parameter int unsigned DEFAULT_DIV = 270
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output logic [DIV_W-1:0] div_q,
    output baud_src_e        src_q,
    output logic             valid_q
);
    localparam logic [DIV_W-1:0] DEF_DIV = DIV_W'(DEFAULT_DIV);

    logic unused_rsvd;
    assign unused_rsvd = ^wdata[CFG_W-1:SRC_BIT+1];

    // Decode and capture the configuration word on each write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q   <= DEF_DIV;
            src_q   <= SRC_FUNC;
            valid_q <= 1'b0;
        end else if (wr) begin
            valid_q <= wdata[USE_BIT];
            if (wdata[USE_BIT]) begin
                div_q <= wdata[DIV_W-1:0];
                src_q <= wdata[SRC_BIT] ? SRC_XTAL : SRC_FUNC;
            end else begin
                div_q <= DEF_DIV;
                src_q <= SRC_FUNC;
            end
        end
    end
endmodule

// File: rtl/baud_prescaler.sv
// Fixed prescaler: divides the functional clock by FUNC_PRE, or the
// crystal strobes by XTAL_PRE. It emits a one-cycle step on the last count.
// Assumes xtal_en is already synchronous to clk.
module baud_prescaler
    import baud_tick_pkg::*;
#(
    parameter int unsigned FUNC_PRE = 4,
    parameter int unsigned XTAL_PRE = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      restart,
    input  baud_src_e src,
    input  logic      xtal_en,
    output logic      step
);
    localparam int unsigned MAXP = (FUNC_PRE > XTAL_PRE) ? FUNC_PRE : XTAL_PRE;
    localparam int unsigned PW   = (MAXP > 2) ? $clog2(MAXP) : 1;
    localparam logic [PW-1:0] F_LIM = PW'(FUNC_PRE - 1);
    localparam logic [PW-1:0] X_LIM = PW'(XTAL_PRE - 1);

    logic [PW-1:0] cnt;
    logic [PW-1:0] lim;
    logic          adv;

    // Pick the source strobe and terminal count for the active mode.
    always_comb begin
        adv  = (src == SRC_XTAL) ? xtal_en : 1'b1;
        lim  = (src == SRC_XTAL) ? X_LIM : F_LIM;
        step = adv && (cnt == lim);
    end

    // Count source strobes, wrapping at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (adv)
            cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/baud_div_counter.sv
// Divisor counter: counts prescaler steps from 0 to div and raises a
// registered one-cycle tick on the step that completes the period.
module baud_div_counter
    import baud_tick_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    // Advance on each step and pulse the tick at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (step) begin
                if (cnt == div) begin
                    cnt  <= '0;
                    tick <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/baud_tick_gen.sv
// Top level: configuration register, dual-source prescaler and divisor
// counter. A configuration write restarts both counters.
// Assumes the crystal reference arrives as a strobe in the clk domain.
module baud_tick_gen
    import baud_tick_pkg::*;
#(
    parameter int unsigned FUNC_PRESCALE = 4,
    parameter int unsigned XTAL_PRESCALE = 3,
    parameter int unsigned DEFAULT_DIV   = 270
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [31:0] cfg_wdata,
    input  logic        xtal_en,
    output logic        bit_tick,
    output logic        cfg_valid
);
    logic [DIV_W-1:0] div_q;
    baud_src_e        src_q;
    logic             pre_step;

    baud_cfg_reg #(.DEFAULT_DIV(DEFAULT_DIV)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .div_q(div_q), .src_q(src_q), .valid_q(cfg_valid)
    );

    baud_prescaler #(.FUNC_PRE(FUNC_PRESCALE), .XTAL_PRE(XTAL_PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .src(src_q),
        .xtal_en(xtal_en), .step(pre_step)
    );

    baud_div_counter u_div (
        .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .step(pre_step),
        .div(div_q), .tick(bit_tick)
    );
endmodule

// File: rtl/baud_tick_gen_checker.sv
// Checker for the tick generator, attached to the top by bind.
module baud_tick_gen_checker
    import baud_tick_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      cfg_wr,
    input logic      wr_use,
    input logic      xtal_en,
    input logic      bit_tick,
    input logic      cfg_valid,
    input baud_src_e src_q
);
    a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !bit_tick);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_valid == $past(wr_use)));

    a_r2_valid_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_valid));

    a_r9_xtal_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && src_q == SRC_XTAL) |-> $past(xtal_en));
endmodule

bind baud_tick_gen baud_tick_gen_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .wr_use(cfg_wdata[baud_tick_pkg::USE_BIT]), .xtal_en(xtal_en),
    .bit_tick(bit_tick), .cfg_valid(cfg_valid), .src_q(src_q)
);

// File: tb/baud_tick_gen_bench.sv
module baud_tick_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xtal_en = 1'b0;
    logic        bit_tick;
    logic        cfg_valid;

    int checks = 0;
    int errors = 0;
    logic [7:0] lfsr = 8'hA5;
    bit rand_en = 1'b1;   // 1: pseudo-random strobe, 0: strobe every cycle

    localparam int DEF_PERIOD = 4 * (270 + 1);

    always #4 clk = ~clk;  // 125 MHz

    baud_tick_gen u_baud_tick_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .xtal_en(xtal_en), .bit_tick(bit_tick), .cfg_valid(cfg_valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic next_en();
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        return rand_en ? lfsr[0] : 1'b1;
    endfunction

    // Write at the next edge; returns at the negedge after the write edge.
    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_wdata = w; xtal_en = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Measure nper intervals; by_en counts strobes instead of cycles.
    task automatic measure(input string tag, input int exp, input bit by_en, input int nper);
        for (int p = 0; p < nper; p++) begin
            int cyc = 0;
            int ecnt = 0;
            logic en;
            do begin
                en = next_en();
                xtal_en = en;
                @(negedge clk);
                cyc++;
                if (en) ecnt++;
                if (cyc == 1 && p > 0) check({tag, " R7 width"}, int'(bit_tick), 0);
            end while (!bit_tick && cyc < 20000);
            check(tag, by_en ? ecnt : cyc, exp);
        end
        xtal_en = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 reset tick", int'(bit_tick), 0);
        check("R1 reset valid", int'(cfg_valid), 0);
        rst_n = 1'b1;
        measure("R1 default period", DEF_PERIOD, 1'b0, 2);
        check("R1 valid stays low", int'(cfg_valid), 0);
    endtask

    task automatic t_func();
        rand_en = 1'b1;
        write_cfg(32'h0080_0009);
        check("R2 valid set", int'(cfg_valid), 1);
        measure("R3 func D=9", 40, 1'b0, 3);
    endtask

    task automatic t_xtal();
        rand_en = 1'b1;
        write_cfg(32'h0180_0004);
        measure("R4 xtal D=4 strobes", 15, 1'b1, 3);
    endtask

    task automatic t_min();
        rand_en = 1'b1;
        write_cfg(32'h0080_0000);
        measure("R8 func D=0", 4, 1'b0, 3);
        rand_en = 1'b0;
        write_cfg(32'h0180_0000);
        measure("R8 xtal D=0", 3, 1'b1, 3);
        rand_en = 1'b1;
    endtask

    task automatic t_ignore();
        write_cfg(32'h0100_0005);
        check("R5 valid low", int'(cfg_valid), 0);
        measure("R5 default wins", DEF_PERIOD, 1'b0, 1);
    endtask

    task automatic t_restart();
        int seen = 0;
        write_cfg(32'h0080_0009);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (bit_tick) seen++;
        end
        check("R6 no early tick", seen, 0);
        write_cfg(32'h0080_0009);
        check("R6 quiet after write", int'(bit_tick), 0);
        measure("R6 restart period", 40, 1'b0, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                t_reset();
                t_func();
                t_xtal();
                t_min();
                t_ignore();
                t_restart();
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule